// File: doc/BRIEF.md
# Overlapping 1011 Serial Pattern Recognizer

This block watches a serial bit stream that arrives one bit per clock on `x` and raises `y` for one cycle whenever the four most recent bits, counting the bit on `x` in the present cycle, read 1, 0, 1, 1 in arrival order. The output is Mealy-type. It is a combinational function of the stored state and the live input, so the flag appears in the same cycle as the final 1 of the pattern, not one cycle later.

Matches may share bits. The closing 1 of one match also serves as the opening 1 of the next. After a false start, the machine keeps the longest tail of the input that is still a valid beginning of the pattern, so it does not fall back to idle.

The stored state is two bits wide and encodes four partial-match states. The upper bit is built as a JK flip-flop, and its J and K inputs come from excitation logic. The lower bit is a D flip-flop that simply loads the current input. The stream has no valid or ready qualifier: every clock edge consumes one bit, so the sender has no way to apply back-pressure, and a source that cannot supply a bit every cycle must gate the clock domain upstream. The reset is synchronous and active-high.

Top module: `serial_match_1011`

## Requirements
- R1: While `rst` is high, `y` is 0 whatever `x` is. The first clock edge with `rst` high returns the machine to idle, meaning no partial match is held, so bits seen before reset can never complete a match afterwards.
- R2: While `rst` is low, `y` is 1 in a cycle exactly when the three bits accepted since reset at the last three edges, followed by the present `x`, are 1, 0, 1, 1 (oldest first). Fewer than three accepted bits count as a non-match.
- R3: Detection overlaps. The run 1011011 applied straight after reset raises `y` on the 4th and the 7th bit and on no other bit.
- R4: After the false start 1010, the input 11 completes a match on the 6th bit. The trailing 10 is kept as a partial match.
- R5: `y` is never high in two consecutive cycles.
- R6: A run of consecutive 1s after reset never raises `y`, however long it is.
- R7: `y` follows `x` within the same cycle. With the history 1, 0, 1 stored, `y` is 0 while `x` is 0 and becomes 1 as soon as `x` goes to 1, with no clock edge in between.
- R8: The lower state bit equals the value `x` had at the previous edge. The upper state bit holds its value at an edge where both its J and K inputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is consumed per rising edge |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| x | input | 1 | Serial data bit for this cycle |
| y | output | 1 | Match flag, high in the cycle whose bit completes 1011 |

## Verification
The bench sweeps every 8-bit sequence from reset and also drives a long mixed stream, the overlap run and a long run of ones. On every cycle it compares `y` with a three-bit history register joined to the live bit. A design that returns to idle after a match misses the second pulse of 1011011. One that drops to idle after 1010 misses the match that follows. A design that registers the output reports every match a cycle late. Reset is also applied in the middle of a partial match and with `x` held high while the machine sits in the last partial state, so a design with an asynchronous or ungated output, or one that holds stale state across reset, produces a visible spurious pulse.

// File: rtl/smatch_pkg.sv
package smatch_pkg;
  localparam int unsigned STATE_W = 2;

  // Partial-match progress; bit 0 always mirrors the last accepted bit.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,  // no useful prefix
    ST_P1   = 2'b01,  // seen 1
    ST_P10  = 2'b10,  // seen 1,0
    ST_P101 = 2'b11   // seen 1,0,1
  } smatch_state_e;
endpackage

// File: rtl/smatch_jk_bit.sv
module smatch_jk_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case ({j, k})
        2'b00:   q <= q;
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        default: q <= ~q;
      endcase
    end
  end
endmodule

// File: rtl/smatch_d_bit.sv
module smatch_d_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/smatch_next.sv
module smatch_next
  import smatch_pkg::*;
(
  input  smatch_state_e cur,
  input  logic          x,
  output logic          j_a,
  output logic          k_a,
  output logic          d_b,
  output logic          hit
);
  smatch_state_e nxt;

  // Longest suffix of (history, x) that is still a prefix of 1011.
  always_comb begin
    hit = 1'b0;
    unique case (cur)
      ST_IDLE: nxt = x ? ST_P1   : ST_IDLE;
      ST_P1:   nxt = x ? ST_P1   : ST_P10;
      ST_P10:  nxt = x ? ST_P101 : ST_IDLE;
      default: begin
        nxt = x ? ST_P1 : ST_P10;
        hit = x;
      end
    endcase
  end

  // JK excitation for the upper bit: set when 0->1, reset when 1->0.
  logic a_now, a_nxt;
  assign a_now = cur[1];
  assign a_nxt = nxt[1];
  assign j_a   = ~a_now & a_nxt;
  assign k_a   = a_now & ~a_nxt;
  assign d_b   = nxt[0];
endmodule

// File: rtl/serial_match_1011.sv
module serial_match_1011
  import smatch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y
);
  logic st_a, st_b;
  logic j_a, k_a, d_b, hit;
  smatch_state_e cur;

  assign cur = smatch_state_e'({st_a, st_b});

  smatch_next u_next (
    .cur (cur),
    .x   (x),
    .j_a (j_a),
    .k_a (k_a),
    .d_b (d_b),
    .hit (hit)
  );

  smatch_jk_bit #(.RST_VAL(1'b0)) u_bit_a (
    .clk (clk), .rst (rst), .j (j_a), .k (k_a), .q (st_a)
  );

  smatch_d_bit #(.RST_VAL(1'b0)) u_bit_b (
    .clk (clk), .rst (rst), .d (d_b), .q (st_b)
  );

  assign y = hit & ~rst;
endmodule

// File: rtl/smatch_chk.sv
module smatch_chk (
  input logic clk,
  input logic rst,
  input logic x,
  input logic y,
  input logic st_a,
  input logic st_b,
  input logic j_a,
  input logic k_a
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |-> !y);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) y |=> !y);

  // R2
  pattern_tail_chk: assert property (@(posedge clk) disable iff (rst)
    y |-> (x && $past(x) && !$past(x, 2) && $past(x, 3)));

  // R8
  d_bit_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (st_b == $past(x)));

  // R8
  jk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(j_a) && !$past(k_a)) |-> (st_a == $past(st_a)));
endmodule

bind serial_match_1011 smatch_chk u_chk (
  .clk (clk), .rst (rst), .x (x), .y (y),
  .st_a (st_a), .st_b (st_b), .j_a (j_a), .k_a (k_a)
);

// File: tb/sim_serial_match_1011.sv
`timescale 1ns/1ps
module sim_serial_match_1011;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic y;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [2:0] hist = 3'b000;
  int nhist = 0;
  logic prev_y = 1'b0;

  always #2.5 clk = ~clk;

  serial_match_1011 u0 (.clk(clk), .rst(rst), .x(x), .y(y));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: y=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One bit: drive after falling edge, sample before the rising edge.
  task automatic step(input logic b, input string tag);
    logic exp;
    @(negedge clk);
    x = b;
    #1;
    exp = (nhist >= 3) && ({hist, b} == 4'b1011);
    check(tag, y, exp);
    check("R5", prev_y & y, 1'b0);
    prev_y = y;
    @(posedge clk);
    hist = {hist[1:0], b};
    nhist++;
  endtask

  task automatic do_reset();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      rst = 1'b1;
      x = 1'b1;
      #1;
      check("R1", y, 1'b0);
      @(posedge clk);
    end
    @(negedge clk);
    rst = 1'b0;
    x = 1'b0;
    hist = 3'b000;
    nhist = 0;
    prev_y = 1'b0;
  endtask

  task automatic run_bits(input logic [63:0] v, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) step(v[i], tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [27:0] mixed;
    mixed = 28'b1110010010011011010110111111;

    // R1: reset with x high, then 0,1,1 must not complete a match
    do_reset();
    run_bits(64'b011, 3, "R1");

    // R1: reset while the machine holds 1,0,1 and x=1
    do_reset();
    run_bits(64'b101, 3, "R2");
    do_reset();
    run_bits(64'b1, 1, "R1");
    run_bits(64'b011, 3, "R1");

    // R2: long mixed stream
    do_reset();
    run_bits({36'd0, mixed}, 28, "R2");

    // R3: overlap
    do_reset();
    run_bits(64'b1011011, 7, "R3");

    // R4: false start keeps its tail
    do_reset();
    run_bits(64'b101011, 6, "R4");

    // R6: long run of ones
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b1, "R6");

    // R7: same-cycle response to x
    do_reset();
    run_bits(64'b101, 3, "R7");
    @(negedge clk);
    x = 1'b0;
    #1;
    check("R7", y, 1'b0);
    x = 1'b1;
    #1;
    check("R7", y, 1'b1);
    @(posedge clk);

    // R2: every 8-bit sequence from reset
    for (int v = 0; v < 256; v++) begin
      do_reset();
      run_bits(64'(v), 8, "R2");
    end

    // R8: lower state bit is the previous input; a run that needs 1 then 0 then 1
    do_reset();
    run_bits(64'b0101011, 7, "R8");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule